// File: doc/BRIEF.md
# Digital Component Video Line Capture Front End

This block sits on the pixel-clock side of a video input port. Every rising edge of the pixel clock it samples one byte of a BT.656-style component video stream. It watches that stream for embedded timing reference codes and uses them alone to decide which bytes belong to a captured line. It packs the active 4:2:2 samples, four bytes at a time, into 32-bit words for a downstream capture FIFO. No separate sync pins are involved.

A timing reference is the four-byte run all-ones, zero, zero, status. In the status byte, bit 7 is always 1, bit 6 is the field bit, bit 5 is the vertical-blanking bit and bit 4 tells the two codes apart: 0 marks start of active video and 1 marks end of active video. Bits 3:0 are protection bits and are ignored. Lines inside vertical blanking are skipped unless blanking-interval capture is enabled.

The source cannot be stalled, so the output is a push interface. `word_valid` is a single-cycle pulse, and a word counts as accepted only if `word_ready` is high in that same cycle. A word offered while `word_ready` is low is lost, and `overflow` is set on the next edge. `overflow` then stays set until reset or until `capture_en` is deasserted. The FIFO must therefore absorb one word every four pixel clocks.

Top module: `vidcap_frontend`

## Requirements
- R1: A timing reference is recognised only as the consecutive bytes 0xFF, 0x00, 0x00 followed by a status byte with bit 7 set. Inside a line, the same three bytes followed by a status byte with bit 7 clear are ordinary pixel data.
- R2: After a start code (status bit 4 = 0), the following bytes are packed in arrival order into 32-bit words: first byte in bits 7:0, second in 15:8, third in 23:16, fourth in 31:24. The byte phase restarts at bits 7:0 after every start code.
- R3: An end code (status bit 4 = 1) stops capture. No word is emitted from the end code's own bytes, from a trailing partial word, or from bytes between lines.
- R4: With `vbi_capture_en` low, a line whose start code has bit 5 set is not captured. With `vbi_capture_en` high, bit 5 has no effect.
- R5: The first word of each captured line has `word_sol` = 1 and `word_field` equal to bit 6 of that line's start code. Later words of the line have `word_sol` = 0.
- R6: `word_valid` never stays high for two cycles in a row. A word offered while `word_ready` is low is dropped and `overflow` is set. `overflow` then stays set while `capture_en` stays high.
- R7: While `capture_en` is low, no word is emitted, `overflow` is cleared and any line in progress is abandoned. Capture resumes only at the next start code.
- R8: After reset, `word_valid`, `word_sol` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | External pixel clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to pix_clk |
| vid_byte | input | 8 | Video byte stream, one byte per clock |
| capture_en | input | 1 | Enables capture; low abandons the line and clears overflow |
| vbi_capture_en | input | 1 | Also capture lines flagged as vertical blanking |
| word_valid | output | 1 | Single-cycle pulse: packed word available |
| word_ready | input | 1 | FIFO can accept the word offered this cycle |
| word_data | output | 32 | Packed word, first byte in bits 7:0 |
| word_sol | output | 1 | Word is the first of its line |
| word_field | output | 1 | Field bit of the line's start code |
| overflow | output | 1 | Sticky: a word was offered while word_ready was low |

## Verification
A wrong byte phase shows up as lanes rotated in `word_data` on the first word of a line, one word after the start code's bytes have passed. A stale line-active state shows up as words appearing after an end code, or with capture disabled, within four clocks. A missed skip of the code bytes puts 0x00 or status bytes into the first word. Overflow bookkeeping errors appear on `overflow` one clock after the dropped pulse, and again whenever capture is re-enabled.

// File: rtl/vc_pkg.sv
package vc_pkg;

  // Decoded status-byte fields of one timing reference
  typedef struct packed {
    logic field;   // field identifier
    logic vblank;  // line lies in vertical blanking
    logic eoav;    // 1 = end of active video, 0 = start
  } trs_t;

  // Bit positions inside the status byte, counted down from its MSB
  localparam int unsigned MARK_OFS  = 1;
  localparam int unsigned FIELD_OFS = 2;
  localparam int unsigned VBLK_OFS  = 3;
  localparam int unsigned EOAV_OFS  = 4;

endpackage

// File: rtl/vc_trs_detect.sv
module vc_trs_detect
  import vc_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned PRE_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              code_hit,
  output trs_t              trs,
  output logic [BYTE_W-1:0] byte_out
);

  // hist_q[0] is the newest byte, hist_q[PRE_LEN-1] the oldest
  logic [BYTE_W-1:0] hist_q [PRE_LEN];
  logic              pre_ok;

  for (genvar i = 0; i < PRE_LEN; i++) begin : g_hist
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) hist_q[0] <= '0;
        else        hist_q[0] <= byte_in;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) hist_q[i] <= '0;
        else        hist_q[i] <= hist_q[i-1];
      end
    end
  end

  always_comb begin
    pre_ok = (hist_q[PRE_LEN-1] == {BYTE_W{1'b1}});
    for (int i = 0; i < PRE_LEN - 1; i++) begin
      pre_ok = pre_ok && (hist_q[i] == '0);
    end
  end

  assign code_hit  = pre_ok && byte_in[BYTE_W-MARK_OFS];
  assign trs.field = byte_in[BYTE_W-FIELD_OFS];
  assign trs.vblank = byte_in[BYTE_W-VBLK_OFS];
  assign trs.eoav  = byte_in[BYTE_W-EOAV_OFS];
  // Byte leaving the history: PRE_LEN clocks old, never yet known to be a code
  assign byte_out  = hist_q[PRE_LEN-1];

endmodule

// File: rtl/vc_line_gate.sv
module vc_line_gate
  import vc_pkg::*;
#(
  parameter int unsigned SKIP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic vbi_en,
  input  logic code_hit,
  input  trs_t trs,
  input  logic word_done,
  output logic take,
  output logic restart,
  output logic sol_pend,
  output logic field
);

  localparam int unsigned SK_W = $clog2(SKIP + 1);

  logic            in_line_q;
  logic [SK_W-1:0] skip_q;
  logic            sav_ok;

  assign sav_ok = !trs.eoav && (vbi_en || !trs.vblank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_line_q <= 1'b0;
      skip_q    <= '0;
      sol_pend  <= 1'b0;
      field     <= 1'b0;
    end else if (!cap_en) begin
      in_line_q <= 1'b0;
      skip_q    <= '0;
      sol_pend  <= 1'b0;
    end else if (code_hit) begin
      in_line_q <= sav_ok;
      skip_q    <= SK_W'(SKIP);
      if (sav_ok) begin
        sol_pend <= 1'b1;
        field    <= trs.field;
      end
    end else begin
      if (skip_q != '0) skip_q <= skip_q - 1'b1;
      if (word_done)    sol_pend <= 1'b0;
    end
  end

  assign take    = cap_en && in_line_q && (skip_q == '0) && !code_hit;
  assign restart = code_hit || !cap_en;

  // R3: no byte is consumed in the cycle after an end code
  assert_eav_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && code_hit && trs.eoav) |=> !take);

  // R4: a blanking line is not opened while blanking capture is off
  assert_vblank_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && code_hit && trs.vblank && !vbi_en) |=> !in_line_q);

  // R2: the code's own trailing bytes are never consumed after a start code
  assert_skip_after_sav_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && code_hit) |=> !take);

endmodule

// File: rtl/vc_word_pack.sv
module vc_word_pack #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_en,
  input  logic                     take,
  input  logic                     restart,
  input  logic [BYTE_W-1:0]        byte_in,
  input  logic                     sol_in,
  input  logic                     field_in,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [BYTE_W*LANES-1:0]  out_data,
  output logic                     out_sol,
  output logic                     out_field,
  output logic                     word_done,
  output logic                     ovf
);

  localparam int unsigned WORD_W = BYTE_W * LANES;
  localparam int unsigned PH_W   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(LANES - 1);

  logic [PH_W-1:0]   phase_q;
  logic [BYTE_W-1:0] lane_q [LANES-1];
  logic [WORD_W-1:0] word_next;

  assign word_done = take && (phase_q == LAST);

  for (genvar i = 0; i < LANES - 1; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                                 lane_q[i] <= '0;
      else if (take && (phase_q == PH_W'(i)))     lane_q[i] <= byte_in;
    end
    assign word_next[i*BYTE_W +: BYTE_W] = lane_q[i];
  end
  assign word_next[WORD_W-1 -: BYTE_W] = byte_in;

  always_ff @(posedge clk) begin
    if (!rst_n)        phase_q <= '0;
    else if (restart)  phase_q <= '0;
    else if (take)     phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sol   <= 1'b0;
      out_field <= 1'b0;
    end else begin
      out_valid <= word_done;
      out_sol   <= word_done && sol_in;
      if (word_done) begin
        out_data  <= word_next;
        out_field <= field_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       ovf <= 1'b0;
    else if (!cap_en)                 ovf <= 1'b0;
    else if (out_valid && !out_ready) ovf <= 1'b1;
  end

  // R5: the line-start tag only rides on a valid word
  assert_sol_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_sol |-> out_valid);

  // R6: valid is a one-cycle pulse
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6: a refused word raises overflow
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && out_valid && !out_ready) |=> ovf);

  // R6: overflow is sticky while capture stays enabled
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && ovf) |=> ovf);

  // R7: disabling capture clears overflow and silences output
  assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> (!ovf && !out_valid));

endmodule

// File: rtl/vidcap_frontend.sv
module vidcap_frontend
  import vc_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned LANES   = 4,
  parameter int unsigned PRE_LEN = 3
) (
  input  logic                    pix_clk,
  input  logic                    rst_n,
  input  logic [BYTE_W-1:0]       vid_byte,
  input  logic                    capture_en,
  input  logic                    vbi_capture_en,
  output logic                    word_valid,
  input  logic                    word_ready,
  output logic [BYTE_W*LANES-1:0] word_data,
  output logic                    word_sol,
  output logic                    word_field,
  output logic                    overflow
);

  logic              code_hit;
  trs_t              trs;
  logic [BYTE_W-1:0] pipe_byte;
  logic              take;
  logic              restart;
  logic              sol_pend;
  logic              line_field;
  logic              word_done;

  vc_trs_detect #(
    .BYTE_W  (BYTE_W),
    .PRE_LEN (PRE_LEN)
  ) u_detect (
    .clk      (pix_clk),
    .rst_n    (rst_n),
    .byte_in  (vid_byte),
    .code_hit (code_hit),
    .trs      (trs),
    .byte_out (pipe_byte)
  );

  vc_line_gate #(
    .SKIP (PRE_LEN)
  ) u_gate (
    .clk       (pix_clk),
    .rst_n     (rst_n),
    .cap_en    (capture_en),
    .vbi_en    (vbi_capture_en),
    .code_hit  (code_hit),
    .trs       (trs),
    .word_done (word_done),
    .take      (take),
    .restart   (restart),
    .sol_pend  (sol_pend),
    .field     (line_field)
  );

  vc_word_pack #(
    .BYTE_W (BYTE_W),
    .LANES  (LANES)
  ) u_pack (
    .clk       (pix_clk),
    .rst_n     (rst_n),
    .cap_en    (capture_en),
    .take      (take),
    .restart   (restart),
    .byte_in   (pipe_byte),
    .sol_in    (sol_pend),
    .field_in  (line_field),
    .out_ready (word_ready),
    .out_valid (word_valid),
    .out_data  (word_data),
    .out_sol   (word_sol),
    .out_field (word_field),
    .word_done (word_done),
    .ovf       (overflow)
  );

endmodule

// File: tb/vidcap_frontend_tb_top.sv
`timescale 1ns/1ps
module vidcap_frontend_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  vid = 8'h10;
  logic        cap_en = 1'b1;
  logic        vbi_en = 1'b0;
  logic        ready = 1'b1;
  logic        valid;
  logic [31:0] data;
  logic        sol;
  logic        fld;
  logic        ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] got_data [256];
  logic        got_sol  [256];
  logic        got_fld  [256];
  int          got_n  = 0;
  int          drop_n = 0;

  always #2 clk = ~clk;

  vidcap_frontend dut_i (
    .pix_clk        (clk),
    .rst_n          (rst_n),
    .vid_byte       (vid),
    .capture_en     (cap_en),
    .vbi_capture_en (vbi_en),
    .word_valid     (valid),
    .word_ready     (ready),
    .word_data      (data),
    .word_sol       (sol),
    .word_field     (fld),
    .overflow       (ovf)
  );

  // Monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (ready) begin
        if (got_n < 256) begin
          got_data[got_n] = data;
          got_sol[got_n]  = sol;
          got_fld[got_n]  = fld;
        end
        got_n = got_n + 1;
      end else begin
        drop_n = drop_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(posedge clk);
    #1 vid = b;
  endtask

  task automatic send_code(input logic [7:0] st);
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(st);
  endtask

  task automatic blank(input int n);
    for (int i = 0; i < n; i++) send_byte((i % 2 == 0) ? 8'h80 : 8'h10);
  endtask

  task automatic send_line(input logic [7:0] sav, input int nbytes, input logic [7:0] base);
    send_code(sav);
    for (int i = 0; i < nbytes; i++) send_byte(base + 8'(i));
    send_code(sav | 8'h10);
    blank(8);
  endtask

  task automatic check_words(input string req, input int start, input int nw,
                             input logic [7:0] base, input logic exp_fld);
    for (int k = 0; k < nw; k++) begin
      logic [31:0] e;
      for (int j = 0; j < 4; j++) e[j*8 +: 8] = base + 8'(4*k + j);
      chk(got_data[start+k] === e, req, got_data[start+k], e);
      chk(got_sol[start+k] === (k == 0), {req, " R5 sol"}, 32'(got_sol[start+k]), 32'(k == 0));
      if (k == 0) chk(got_fld[start] === exp_fld, {req, " R5 field"}, 32'(got_fld[start]), 32'(exp_fld));
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(valid === 1'b0, "R8 valid", 32'(valid), 0);
    chk(sol === 1'b0, "R8 sol", 32'(sol), 0);
    chk(ovf === 1'b0, "R8 overflow", 32'(ovf), 0);
  endtask

  task automatic t_basic;
    int s = got_n;
    send_line(8'h80, 12, 8'h20);
    chk(got_n - s == 3, "R2 word count", 32'(got_n - s), 3);
    check_words("R2 packing", s, 3, 8'h20, 1'b0);
  endtask

  task automatic t_field;
    int s = got_n;
    send_line(8'hC0, 8, 8'h40);
    chk(got_n - s == 2, "R5 count", 32'(got_n - s), 2);
    check_words("R5 field one", s, 2, 8'h40, 1'b1);
  endtask

  task automatic t_vbi;
    int s;
    vbi_en = 1'b0;
    s = got_n;
    send_line(8'hA0, 8, 8'h50);
    chk(got_n - s == 0, "R4 blanking line skipped", 32'(got_n - s), 0);
    vbi_en = 1'b1;
    s = got_n;
    send_line(8'hA0, 8, 8'h50);
    chk(got_n - s == 2, "R4 blanking line captured", 32'(got_n - s), 2);
    check_words("R4 data", s, 2, 8'h50, 1'b0);
    s = got_n;
    send_line(8'h80, 4, 8'h58);
    chk(got_n - s == 1, "R4 active line with vbi on", 32'(got_n - s), 1);
    vbi_en = 1'b0;
  endtask

  task automatic t_partial;
    int s = got_n;
    send_line(8'h80, 9, 8'h60);
    chk(got_n - s == 2, "R3 partial word dropped", 32'(got_n - s), 2);
    check_words("R3 data", s, 2, 8'h60, 1'b0);
  endtask

  task automatic t_fake_code;
    int s = got_n;
    send_code(8'h80);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(8'h40);
    send_byte(8'h55); send_byte(8'h66); send_byte(8'h77); send_byte(8'h88);
    send_code(8'h90);
    blank(8);
    chk(got_n - s == 3, "R1 bit7-clear status is data", 32'(got_n - s), 3);
    chk(got_data[s+1] === 32'h400000FF, "R1 embedded bytes", got_data[s+1], 32'h400000FF);
    chk(got_data[s+2] === 32'h88776655, "R1 phase after", got_data[s+2], 32'h88776655);
  endtask

  task automatic t_overflow;
    int s = got_n;
    int d = drop_n;
    ready = 1'b0;
    send_line(8'h80, 8, 8'h70);
    chk(got_n - s == 0, "R6 nothing accepted", 32'(got_n - s), 0);
    chk(drop_n - d == 2, "R6 dropped pulses", 32'(drop_n - d), 2);
    @(negedge clk);
    chk(ovf === 1'b1, "R6 overflow set", 32'(ovf), 1);
    ready = 1'b1;
    s = got_n;
    send_line(8'h80, 8, 8'h70);
    @(negedge clk);
    chk(ovf === 1'b1, "R6 overflow sticky", 32'(ovf), 1);
    chk(got_n - s == 2, "R6 capture after drop", 32'(got_n - s), 2);
    @(posedge clk); #1 cap_en = 1'b0;
    @(posedge clk); #1 cap_en = 1'b1;
    @(negedge clk);
    chk(ovf === 1'b0, "R7 overflow cleared", 32'(ovf), 0);
  endtask

  task automatic t_cap_off;
    int s = got_n;
    cap_en = 1'b0;
    send_line(8'h80, 8, 8'h30);
    chk(got_n - s == 0, "R7 disabled line", 32'(got_n - s), 0);
    cap_en = 1'b1;
    s = got_n;
    send_code(8'h80);
    for (int i = 0; i < 4; i++) send_byte(8'h30 + 8'(i));
    cap_en = 1'b0;
    send_byte(8'h34); send_byte(8'h35);
    cap_en = 1'b1;
    for (int i = 6; i < 14; i++) send_byte(8'h30 + 8'(i));
    send_code(8'h90);
    blank(8);
    chk(got_n - s == 0, "R7 line abandoned", 32'(got_n - s), 0);
    s = got_n;
    send_line(8'h80, 4, 8'h24);
    chk(got_n - s == 1, "R7 resumes at next start", 32'(got_n - s), 1);
    check_words("R7 data", s, 1, 8'h24, 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    blank(6);
    t_basic();
    t_field();
    t_vbi();
    t_partial();
    t_fake_code();
    t_overflow();
    t_cap_off();
    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule